// File: doc/BRIEF.md
# Programmable Gated Memory Clock Generator

This block derives a slow interface clock for a memory array from the fast bus clock. The period is set in bus-clock units through a 6-bit field. Each generated period starts with its high phase and ends with its low phase. On the last bus cycle of every period the block raises a strobe, so that an access sequencer can step its own state at clock-cycle granularity.

In the default gated mode the clock runs only while an access is requested. It always starts at a period boundary, and a period that has begun always runs to its end. Between accesses it inserts an idle bus cycle. A suppress option removes that idle gap, so that back-to-back accesses appear as consecutive periods. A continuous option keeps the clock running whether or not an access is pending. An access then has to wait for the next boundary, which costs extra latency.

Top module: `mclk_gen`

## Requirements
- R1: With an effective setting E, each generated period lasts exactly E+1 bus cycles. `boundary_o` is high on the last cycle of each period and on no other cycle.
- R2: Each period begins with `mclk_o` high for floor((E+1)/2) cycles, followed by low for the remaining cycles.
- R3: A `period_i` value of 0 is treated as an effective setting of 15. Values 1 to 63 are used as given.
- R4: `period_i` is sampled only when a period starts. A change during a period takes effect at the next period.
- R5: In gated mode an idle generator holds `mclk_o` low and starts a period on the first clock edge that samples `access_i` high. A started period always completes, even if `access_i` falls during it.
- R6: In gated mode without suppress, at least one idle bus cycle with `mclk_o` low follows each period before the next period starts.
- R7: With `suppress_i` high, if `access_i` is high at the end of a period, the next period starts on the following cycle with no idle gap. If `access_i` is low, the generator stops.
- R8: With `continuous_i` high, periods follow one another with no gap regardless of `access_i`. After `continuous_i` is cleared, the current period completes.
- R9: During and after reset, `mclk_o` and `boundary_o` are low until a period starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_i | input | 6 | Period setting; period is setting+1 bus cycles, 0 means 15 |
| continuous_i | input | 1 | Keep the generated clock free-running |
| suppress_i | input | 1 | Remove the idle gap between back-to-back accesses |
| access_i | input | 1 | Access requested by the sequencer |
| mclk_o | output | 1 | Generated clock level, registered |
| boundary_o | output | 1 | High on the last bus cycle of each generated period |

## Verification
The hardest case to reach is a setting change that lands in the middle of a running period. It only shows if the old period length is kept to the end and the new length then appears without a lost or extra cycle. The stimulus runs the clock in continuous mode and changes `period_i` one cycle after a period starts. The expected stream then holds a full long period followed by short ones. Similar mid-period drops of `access_i` and `continuous_i` check that the last period still completes. In gated mode, a request held high across a boundary shows the difference between the idle gap and the suppressed gap.

// File: rtl/mclk_gen_pkg.sv
package mclk_gen_pkg;
  localparam int unsigned PER_W    = 6;
  localparam int unsigned PER_DFLT = 15;
endpackage

// File: rtl/mclk_per_sel.sv
module mclk_per_sel #(
  parameter int unsigned PER_W    = mclk_gen_pkg::PER_W,
  parameter int unsigned PER_DFLT = mclk_gen_pkg::PER_DFLT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PER_W-1:0] period_i,
  input  logic             load_i,
  output logic [PER_W-1:0] per_o,
  output logic [PER_W-1:0] per_nxt_o
);
  localparam logic [PER_W-1:0] DFLT = PER_W'(PER_DFLT);

  logic [PER_W-1:0] eff;
  logic [PER_W-1:0] per_q;

  assign eff       = (period_i == '0) ? DFLT : period_i;
  assign per_nxt_o = load_i ? eff : per_q;
  assign per_o     = per_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) per_q <= DFLT;
    else         per_q <= per_nxt_o;
  end

  // R3
  per_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_q != '0);
endmodule

// File: rtl/mclk_run_ctl.sv
module mclk_run_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic at_end_i,
  input  logic access_i,
  input  logic continuous_i,
  input  logic suppress_i,
  output logic run_o,
  output logic run_nxt_o,
  output logic load_o
);
  logic run_q;
  logic go;

  // from idle any request starts; at a period end only continuous or suppress chains
  assign go        = run_q ? (continuous_i | (suppress_i & access_i))
                           : (continuous_i | access_i);
  assign load_o    = (!run_q | at_end_i) & go;
  assign run_nxt_o = (run_q & !at_end_i) | load_o;
  assign run_o     = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= run_nxt_o;
  end

  // R5
  no_partial_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !at_end_i) |=> run_q);

  // R8
  cont_keeps_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && continuous_i) |=> run_q);
endmodule

// File: rtl/mclk_phase_cnt.sv
module mclk_phase_cnt #(
  parameter int unsigned PER_W = mclk_gen_pkg::PER_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             run_nxt_i,
  input  logic             load_i,
  input  logic [PER_W-1:0] per_i,
  input  logic [PER_W-1:0] per_nxt_i,
  output logic             at_end_o,
  output logic             mclk_o
);
  logic [PER_W-1:0] cnt_q, cnt_d;
  logic [PER_W:0]   hi_nxt;
  logic             mclk_q, mclk_d;

  assign at_end_o = run_i && (cnt_q == per_i);
  assign hi_nxt   = ({1'b0, per_nxt_i} + (PER_W+1)'(1)) >> 1;

  always_comb begin
    if (load_i)                 cnt_d = '0;
    else if (run_i && !at_end_o) cnt_d = cnt_q + PER_W'(1);
    else                        cnt_d = '0;
    mclk_d = run_nxt_i && ({1'b0, cnt_d} < hi_nxt);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      mclk_q <= mclk_d;
    end
  end

  assign mclk_o = mclk_q;

  // R1
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= per_i);

  // R2
  high_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_q == '0) |-> mclk_q);

  // R5
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !mclk_q);
endmodule

// File: rtl/mclk_gen.sv
module mclk_gen #(
  parameter int unsigned PER_W    = mclk_gen_pkg::PER_W,
  parameter int unsigned PER_DFLT = mclk_gen_pkg::PER_DFLT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PER_W-1:0] period_i,
  input  logic             continuous_i,
  input  logic             suppress_i,
  input  logic             access_i,
  output logic             mclk_o,
  output logic             boundary_o
);
  logic             at_end, run, run_nxt, load;
  logic [PER_W-1:0] per_q, per_nxt;

  mclk_per_sel #(.PER_W(PER_W), .PER_DFLT(PER_DFLT)) u_per (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .period_i (period_i),
    .load_i   (load),
    .per_o    (per_q),
    .per_nxt_o(per_nxt)
  );

  mclk_run_ctl u_run (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .at_end_i    (at_end),
    .access_i    (access_i),
    .continuous_i(continuous_i),
    .suppress_i  (suppress_i),
    .run_o       (run),
    .run_nxt_o   (run_nxt),
    .load_o      (load)
  );

  mclk_phase_cnt #(.PER_W(PER_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .run_nxt_i(run_nxt),
    .load_i   (load),
    .per_i    (per_q),
    .per_nxt_i(per_nxt),
    .at_end_o (at_end),
    .mclk_o   (mclk_o)
  );

  assign boundary_o = at_end;

  // R4
  per_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !at_end) |=> $stable(per_q));

  // R6
  gated_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_o && !continuous_i && !suppress_i) |=> (!mclk_o && !boundary_o));
endmodule

// File: tb/mclk_gen_tb_top.sv
module mclk_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] period = 6'd15;
  logic       cont = 1'b0;
  logic       supp = 1'b0;
  logic       acc = 1'b0;
  logic       mclk, bnd;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  typedef struct {
    bit    m;
    bit    b;
    string r;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  mclk_gen dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .period_i    (period),
    .continuous_i(cont),
    .suppress_i  (supp),
    .access_i    (acc),
    .mclk_o      (mclk),
    .boundary_o  (bnd)
  );

  task automatic check(input string r, input bit am, input bit ab, input bit em, input bit eb);
    total++;
    if (am !== em || ab !== eb) begin
      bad++;
      $display("FAIL %s: mclk/boundary actual=%0b/%0b expected=%0b/%0b at %0t",
               r, am, ab, em, eb, $time);
    end
  endtask

  // monitor: one expected item per edge, sampled 2 ns after it
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.r, mclk, bnd, e.m, e.b);
    end
  end

  // called at a negedge: item describes outputs after the next posedge
  task automatic cyc(input bit m, input bit b, input string r);
    exp_t e;
    e.m = m; e.b = b; e.r = r;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string r);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, r);
  endtask

  task automatic period_run(input int eff, input string r, input bit drop = 1'b0, input int chg = -1);
    for (int i = 0; i <= eff; i++) begin
      cyc(i < (eff + 1) / 2, i == eff, r);
      if (i == 0 && drop) begin acc = 1'b0; cont = 1'b0; end
      if (i == 0 && chg >= 0) period = 6'(chg);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    check("R9", mclk, bnd, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", mclk, bnd, 1'b0, 1'b0);

    // R5: idle with no request
    idle(3, "R5");

    // gated, setting 3: gap between periods, then request drops mid period
    period = 6'd3; acc = 1'b1;
    period_run(3, "R1");
    idle(1, "R6");
    period_run(3, "R5", 1'b1);
    idle(3, "R5");

    // zero setting maps to 15
    period = 6'd0; acc = 1'b1;
    period_run(15, "R3", 1'b1);
    idle(2, "R3");

    // suppress, setting 4 (2 high, 3 low)
    period = 6'd4; supp = 1'b1; acc = 1'b1;
    period_run(4, "R2");
    period_run(4, "R7");
    period_run(4, "R7", 1'b1);
    idle(2, "R7");
    supp = 1'b0;

    // continuous, setting change mid period
    period = 6'd7; cont = 1'b1;
    period_run(7, "R8");
    period_run(7, "R4", 1'b0, 2);
    period_run(2, "R4");
    period_run(2, "R8", 1'b1);
    idle(3, "R8");

    // smallest setting with suppress
    period = 6'd1; supp = 1'b1; acc = 1'b1;
    period_run(1, "R2");
    period_run(1, "R2", 1'b1);
    idle(2, "R2");
    supp = 1'b0;

    // largest setting
    period = 6'd63; acc = 1'b1;
    period_run(63, "R1", 1'b1);
    idle(2, "R1");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule